// File: doc/BRIEF.md
# Serial-Access Configuration Word Store

This block keeps a 64-word by 16-bit configuration image in on-chip storage and offers two software-visible ways to read it. The first is a bit-banged serial port: software writes a control register whose low bits stand for a select line, a shift clock and a data-in line. It reads a data-out bit back from the same register. A 9-bit command is shifted in on rising clock edges. Once that command decodes as a read, the addressed word is presented one bit per falling clock edge, starting with the most significant bit. The read runs on through the following words for as long as clocking continues.

The second path is a direct-lookup register. Software writes a go flag and an 8-bit word index, then reads back a done flag with the word in the upper half. A loader port fills the image. A seal pulse then copies a 48-bit station address into words 0 to 2, two bytes per word with the lower byte in the low half. After that the block spends 63 cycles adding up words 0 to 62 and writes word 63 so that all 64 words sum to 16'hBABA. `img_ready` marks the end of this computation.

Top module: `eeprom_emu`

## Requirements
- R1: After reset the control read value is 32'h0000_0068, with bit 6 (present) = 1, bit 5 (grant) = 1 and bit 3 (data out) = 1. All other bits are 0. The direct register reads 0, every image word is 0 and `img_ready` is 0.
- R2: A control write with bit 1 (select) = 0 only stores bits 0 (clock), 1 (select), 2 (data in) and 4 (request), which read back in the same positions. The serial state does not move, so data out holds its value.
- R3: A control write that takes select from 0 to 1 clears the command shift value, the command bit count, the output bit pointer and the read flag. Data out then reads 1.
- R4: With select = 1, a write that raises bit 0 shifts bit 2 into the command. On the ninth rise, if no read is active, command bits [8:6] are the opcode and bits [5:0] the word address. Opcode 3'b110 starts a read with the bit pointer set to address*16-1.
- R5: Each write that lowers bit 0 while select = 1 advances the 10-bit pointer. Data out is bit 15-p[3:0] of word p[9:4]. Words therefore come out most significant bit first, continue into the following word, and wrap from word 63 to word 0.
- R6: Any opcode other than 3'b110 starts no read. Data out reads 1 whenever no read is active.
- R7: Control read bits 6 and 5 are always 1.
- R8: A direct-register write stores bits [15:0]. When stored bit 0 (go) = 0, the register reads back {16'h0, stored}.
- R9: With go = 1 and index field bits [15:8] above 63, the read value is {16'h0, stored with bit 0 cleared and bit 1 (done) set}.
- R10: With go = 1 and index at most 63, the read value is {word[index], stored with bit 0 cleared and bit 1 set}.
- R11: On an accepted seal, word i (i = 0..2) becomes {mac_addr[16i+15:16i+8], mac_addr[16i+7:16i]}.
- R12: `img_ready` drops on an accepted seal and rises exactly 63 clock edges later. At that point the 16-bit sum of all 64 words equals 16'hBABA.
- R13: Loader writes to word 63 are ignored, as are loader writes in the cycle a seal is accepted or while the sum is running. A seal during the sum is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_rdata | output | 32 | Control register read value |
| dr_wr | input | 1 | Direct-lookup register write strobe |
| dr_wdata | input | 32 | Direct-lookup register write value |
| dr_rdata | output | 32 | Direct-lookup register read value |
| img_wr | input | 1 | Image loader write strobe |
| img_addr | input | 6 | Image loader word index |
| img_data | input | 16 | Image loader word value |
| seal | input | 1 | Insert station address and start the checksum |
| mac_addr | input | 48 | Station address, byte 0 in bits [7:0] |
| img_ready | output | 1 | Checksum word valid |

## Verification
The hold check on data out assumes that while select is low, neither the loader nor the checksum engine rewrites the word under the pointer. The bench therefore keeps the loader and the seal idle during every serial sequence. The latency check follows its own seal window and assumes one seal per window. The bench issues a single seal and fires loader traffic into that window only to show it is dropped. All register traffic is one write per cycle, driven on the falling clock edge.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;
    // image geometry
    localparam int ADDR_W    = 6;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int WORD_W    = 16;
    localparam int BIT_W     = $clog2(WORD_W);
    localparam int PTR_W     = ADDR_W + BIT_W;
    localparam int OP_W      = 3;
    localparam int CMD_W     = OP_W + ADDR_W;
    localparam int NIN_W     = $clog2(CMD_W + 1) + 1;
    localparam int MAC_WORDS = 3;
    localparam int MAC_W     = MAC_WORDS * WORD_W;
    localparam int REG_W     = 32;

    localparam logic [OP_W-1:0]   OP_READ   = 3'b110;
    localparam logic [WORD_W-1:0] SIGNATURE = 16'hBABA;

    // control register bit positions
    localparam int CB_CLK  = 0;
    localparam int CB_SEL  = 1;
    localparam int CB_DIN  = 2;
    localparam int CB_DOUT = 3;
    localparam int CB_REQ  = 4;
    localparam int CB_GNT  = 5;
    localparam int CB_PRES = 6;

    // direct-lookup register fields
    localparam int DB_GO      = 0;
    localparam int DB_DONE    = 1;
    localparam int DR_IDX_LSB = 8;
    localparam int DR_IDX_W   = 8;
    localparam int DR_LO_W    = 16;

    typedef struct packed {
        logic req;
        logic din;
        logic sel;
        logic sclk;
    } pin_bits_t;

    typedef struct packed {
        logic [CMD_W-1:0] shreg;
        logic [NIN_W-1:0] nin;
        logic [PTR_W-1:0] ptr;
        logic             reading;
    } serial_st_t;

    function automatic logic [WORD_W-1:0] mac_word(input logic [MAC_W-1:0] mac,
                                                   input int unsigned idx);
        return mac[idx*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/mw_serial.sv
module mw_serial
    import eeprom_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  pin_bits_t         wr_bits,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output pin_bits_t         held,
    output logic              dout
);
    serial_st_t st, nst;

    always_comb begin
        nst = st;
        if (wr_en && wr_bits.sel) begin
            if (!held.sel) begin
                nst.shreg   = '0;
                nst.nin     = '0;
                nst.ptr     = '0;
                nst.reading = 1'b0;
            end
            if (wr_bits.sclk != held.sclk) begin
                if (!wr_bits.sclk) begin
                    nst.ptr = nst.ptr + PTR_W'(1);
                end else begin
                    nst.shreg = {nst.shreg[CMD_W-2:0], wr_bits.din};
                    if (nst.nin != '1) nst.nin = nst.nin + NIN_W'(1);
                    if (nst.nin == NIN_W'(CMD_W) && !nst.reading) begin
                        nst.ptr     = {nst.shreg[ADDR_W-1:0], {BIT_W{1'b0}}} - PTR_W'(1);
                        nst.reading = (nst.shreg[CMD_W-1 -: OP_W] == OP_READ);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            held <= '0;
        end else begin
            st <= nst;
            if (wr_en) held <= wr_bits;
        end
    end

    assign rd_addr = st.ptr[PTR_W-1:BIT_W];
    assign dout    = !st.reading || rd_word[~st.ptr[BIT_W-1:0]];
endmodule

// File: rtl/eeprom_image.sv
module eeprom_image
    import eeprom_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_wr,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              seal,
    input  logic [MAC_W-1:0]  mac,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [WORD_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [WORD_W-1:0] rb_data,
    output logic              ready
);
    localparam logic [ADDR_W-1:0] LAST_SUMMED = ADDR_W'(DEPTH - 2);
    localparam logic [ADDR_W-1:0] SUM_SLOT    = ADDR_W'(DEPTH - 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic              busy;
    logic [ADDR_W-1:0] idx;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_next;

    assign acc_next = acc + mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            busy  <= 1'b0;
            idx   <= '0;
            acc   <= '0;
            ready <= 1'b0;
        end else if (seal && !busy) begin
            for (int j = 0; j < MAC_WORDS; j++) mem[j] <= mac_word(mac, j);
            busy  <= 1'b1;
            idx   <= '0;
            acc   <= '0;
            ready <= 1'b0;
        end else if (busy) begin
            acc <= acc_next;
            idx <= idx + ADDR_W'(1);
            if (idx == LAST_SUMMED) begin
                mem[SUM_SLOT] <= SIGNATURE - acc_next;
                busy          <= 1'b0;
                ready         <= 1'b1;
            end
        end else if (ld_wr && ld_addr != SUM_SLOT) begin
            mem[ld_addr] <= ld_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/direct_read.sv
module direct_read
    import eeprom_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DR_LO_W-1:0] wr_lo,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rdata
);
    logic [DR_LO_W-1:0]  stored;
    logic [DR_LO_W-1:0]  cleared;
    logic [DR_IDX_W-1:0] index;
    logic                in_range;

    always_ff @(posedge clk) begin
        if (rst)        stored <= '0;
        else if (wr_en) stored <= wr_lo;
    end

    always_comb begin
        cleared          = stored;
        cleared[DB_GO]   = 1'b0;
        index            = stored[DR_IDX_LSB +: DR_IDX_W];
        in_range         = index < DR_IDX_W'(DEPTH);
        rd_addr          = index[ADDR_W-1:0];
        if (!stored[DB_GO]) begin
            rdata = {{(REG_W-DR_LO_W){1'b0}}, stored};
        end else begin
            cleared[DB_DONE] = 1'b1;
            rdata = {(in_range ? rd_word : {WORD_W{1'b0}}), cleared};
        end
    end
endmodule

// File: rtl/eeprom_emu.sv
module eeprom_emu
    import eeprom_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [REG_W-1:0]  ctl_wdata,
    output logic [REG_W-1:0]  ctl_rdata,
    input  logic              dr_wr,
    input  logic [REG_W-1:0]  dr_wdata,
    output logic [REG_W-1:0]  dr_rdata,
    input  logic              img_wr,
    input  logic [ADDR_W-1:0] img_addr,
    input  logic [WORD_W-1:0] img_data,
    input  logic              seal,
    input  logic [MAC_W-1:0]  mac_addr,
    output logic              img_ready
);
    pin_bits_t         wr_bits;
    pin_bits_t         held;
    logic              dout;
    logic [ADDR_W-1:0] ser_addr, dr_addr;
    logic [WORD_W-1:0] ser_word, dr_word;
    logic              unused_wbits;

    assign wr_bits.sclk = ctl_wdata[CB_CLK];
    assign wr_bits.sel  = ctl_wdata[CB_SEL];
    assign wr_bits.din  = ctl_wdata[CB_DIN];
    assign wr_bits.req  = ctl_wdata[CB_REQ];
    assign unused_wbits = ^{ctl_wdata[REG_W-1:CB_GNT], ctl_wdata[CB_DOUT],
                            dr_wdata[REG_W-1:DR_LO_W]};

    mw_serial u_ser (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctl_wr),
        .wr_bits (wr_bits),
        .rd_word (ser_word),
        .rd_addr (ser_addr),
        .held    (held),
        .dout    (dout)
    );

    eeprom_image u_img (
        .clk     (clk),
        .rst     (rst),
        .ld_wr   (img_wr),
        .ld_addr (img_addr),
        .ld_data (img_data),
        .seal    (seal),
        .mac     (mac_addr),
        .ra_addr (ser_addr),
        .ra_data (ser_word),
        .rb_addr (dr_addr),
        .rb_data (dr_word),
        .ready   (img_ready)
    );

    direct_read u_dr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dr_wr),
        .wr_lo   (dr_wdata[DR_LO_W-1:0]),
        .rd_word (dr_word),
        .rd_addr (dr_addr),
        .rdata   (dr_rdata)
    );

    always_comb begin
        ctl_rdata          = '0;
        ctl_rdata[CB_CLK]  = held.sclk;
        ctl_rdata[CB_SEL]  = held.sel;
        ctl_rdata[CB_DIN]  = held.din;
        ctl_rdata[CB_DOUT] = dout;
        ctl_rdata[CB_REQ]  = held.req;
        ctl_rdata[CB_GNT]  = 1'b1;
        ctl_rdata[CB_PRES] = 1'b1;
    end
endmodule

// File: rtl/eeprom_emu_chk.sv
module eeprom_emu_chk
    import eeprom_emu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctl_wr,
    input logic [REG_W-1:0]  ctl_wdata,
    input logic [REG_W-1:0]  ctl_rdata,
    input logic              dr_wr,
    input logic [REG_W-1:0]  dr_wdata,
    input logic [REG_W-1:0]  dr_rdata,
    input logic              img_wr,
    input logic              seal,
    input logic              img_ready
);
    localparam int WIN_LAST = DEPTH - 2;

    logic       win;
    logic [7:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            win     <= 1'b0;
            win_cnt <= '0;
        end else if (seal && !win) begin
            win     <= 1'b1;
            win_cnt <= '0;
        end else if (win) begin
            win_cnt <= win_cnt + 8'd1;
            if (win_cnt == 8'(WIN_LAST)) win <= 1'b0;
        end
    end

    // R7
    a_r7_status_bits: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[CB_PRES] && ctl_rdata[CB_GNT]);

    // R2
    a_r2_sel_low_hold: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_wdata[CB_SEL] && !img_wr && !seal && !win)
        |=> $stable(ctl_rdata[CB_DOUT]));

    // R3
    a_r3_sel_rise_idle: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[CB_SEL] && !ctl_rdata[CB_SEL])
        |=> ctl_rdata[CB_DOUT]);

    // R8
    a_r8_plain_readback: assert property (@(posedge clk) disable iff (rst)
        (dr_wr && !dr_wdata[DB_GO])
        |=> dr_rdata == {16'h0, $past(dr_wdata[DR_LO_W-1:0])});

    // R9
    a_r9_index_out_of_range: assert property (@(posedge clk) disable iff (rst)
        (dr_wr && dr_wdata[DB_GO] && dr_wdata[DR_IDX_LSB +: DR_IDX_W] > 8'(DEPTH - 1))
        |=> (dr_rdata[REG_W-1:DR_LO_W] == '0 && dr_rdata[DB_DONE] && !dr_rdata[DB_GO]));

    // R10
    a_r10_lookup_done: assert property (@(posedge clk) disable iff (rst)
        (dr_wr && dr_wdata[DB_GO] && dr_wdata[DR_IDX_LSB +: DR_IDX_W] <= 8'(DEPTH - 1))
        |=> (dr_rdata[DB_DONE] && !dr_rdata[DB_GO]));

    // R12
    a_r12_not_ready_in_window: assert property (@(posedge clk) disable iff (rst)
        win |-> !img_ready);

    a_r12_ready_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(img_ready) |-> ($past(win) && $past(win_cnt) == 8'(WIN_LAST)));
endmodule

bind eeprom_emu eeprom_emu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .dr_wr     (dr_wr),
    .dr_wdata  (dr_wdata),
    .dr_rdata  (dr_rdata),
    .img_wr    (img_wr),
    .seal      (seal),
    .img_ready (img_ready)
);

// File: tb/sim_eeprom_emu.sv
`timescale 1ns/1ps
module sim_eeprom_emu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        dr_wr = 1'b0;
    logic [31:0] dr_wdata = '0;
    logic [31:0] dr_rdata;
    logic        img_wr = 1'b0;
    logic [5:0]  img_addr = '0;
    logic [15:0] img_data = '0;
    logic        seal = 1'b0;
    logic [47:0] mac_addr = 48'h6655_4433_2211;
    logic        img_ready;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] model [64];

    always #2 clk = ~clk;

    eeprom_emu u0 (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .dr_wr(dr_wr), .dr_wdata(dr_wdata), .dr_rdata(dr_rdata),
        .img_wr(img_wr), .img_addr(img_addr), .img_data(img_data),
        .seal(seal), .mac_addr(mac_addr), .img_ready(img_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fill(input int i);
        return 16'((i * 16'h0913) ^ 16'hC35A);
    endfunction

    // one control write: select, clock, data in
    task automatic cw(input bit s, input bit c, input bit d);
        @(negedge clk);
        ctl_wr    = 1'b1;
        ctl_wdata = {29'b0, d, s, c};
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic dr_put(input logic [15:0] v, output logic [31:0] r);
        @(negedge clk);
        dr_wr    = 1'b1;
        dr_wdata = {16'h0, v};
        @(negedge clk);
        dr_wr    = 1'b0;
        r = dr_rdata;
    endtask

    task automatic img_put(input int a, input logic [15:0] v);
        @(negedge clk);
        img_wr = 1'b1; img_addr = 6'(a); img_data = v;
        @(negedge clk);
        img_wr = 1'b0;
    endtask

    function automatic bit exp_bit(input int a, input int k);
        int p;
        p = (a * 16 - 1 + k) & 10'h3FF;
        return model[p >> 4][15 - (p & 15)];
    endfunction

    task automatic send_cmd(input logic [2:0] op, input logic [5:0] a);
        logic [8:0] cmd;
        cmd = {op, a};
        cw(0, 0, 0);
        cw(1, 0, 0);
        for (int b = 8; b >= 0; b--) begin
            cw(1, 0, cmd[b]);
            cw(1, 1, cmd[b]);
        end
    endtask

    task automatic t_reset;
        logic [31:0] r;
        chk(ctl_rdata == 32'h68, "R1 ctl reset", ctl_rdata, 32'h68);
        chk(dr_rdata == 32'h0, "R1 direct reset", dr_rdata, 32'h0);
        chk(img_ready == 1'b0, "R1 ready reset", {31'b0, img_ready}, 32'h0);
        dr_put(16'h0501, r);
        chk(r == 32'h0000_0502, "R1 word zero after reset", r, 32'h0000_0502);
    endtask

    task automatic t_load_guard;
        logic [31:0] r;
        img_put(63, 16'h1234);
        dr_put(16'h3F01, r);
        chk(r == 32'h0000_3F02, "R13 word 63 not loadable", r, 32'h0000_3F02);
    endtask

    task automatic t_load_and_seal;
        int first;
        logic [15:0] s;
        for (int i = 0; i < 63; i++) begin
            img_put(i, fill(i));
            model[i] = fill(i);
        end
        @(negedge clk); seal = 1'b1;
        @(negedge clk); seal = 1'b0;
        chk(img_ready == 1'b0, "R12 ready low after seal", {31'b0, img_ready}, 32'h0);
        first = 0;
        for (int n = 1; n <= 63; n++) begin
            @(negedge clk);
            if (n == 5) begin img_wr = 1'b1; img_addr = 6'd10; img_data = 16'hFFFF; end
            if (n == 6) img_wr = 1'b0;
            if (n == 8) seal = 1'b1;
            if (n == 9) seal = 1'b0;
            if (img_ready && first == 0) first = n;
        end
        chk(first == 63, "R12 ready latency", first, 63);
        for (int j = 0; j < 3; j++) model[j] = mac_addr[j*16 +: 16];
        s = 16'h0;
        for (int i = 0; i < 63; i++) s = s + model[i];
        model[63] = 16'hBABA - s;
    endtask

    task automatic t_image_check;
        logic [31:0] r;
        logic [15:0] s;
        int bad;
        bad = 0;
        s = 16'h0;
        for (int i = 0; i < 64; i++) begin
            dr_put({2'b0, 6'(i), 8'h01}, r);
            s = s + r[31:16];
            if (r != {model[i], 2'b0, 6'(i), 8'h02}) begin
                bad++;
                chk(0, "R10 lookup word", r, {model[i], 2'b0, 6'(i), 8'h02});
            end
        end
        chk(bad == 0, "R10 all words", bad, 0);
        chk(s == 16'hBABA, "R12 image sum", s, 32'hBABA);
        dr_put(16'h0001, r);
        chk(r[31:16] == 16'h2211, "R11 mac word 0", r[31:16], 32'h2211);
        dr_put(16'h0201, r);
        chk(r[31:16] == 16'h6655, "R11 mac word 2", r[31:16], 32'h6655);
        dr_put(16'h0A01, r);
        chk(r[31:16] == fill(10), "R13 busy load ignored", r[31:16], fill(10));
    endtask

    task automatic t_direct;
        logic [31:0] r;
        dr_put(16'h5A5C, r);
        chk(r == 32'h0000_5A5C, "R8 plain readback", r, 32'h0000_5A5C);
        dr_put(16'h4001, r);
        chk(r == 32'h0000_4002, "R9 index 64", r, 32'h0000_4002);
        dr_put(16'hFFF1, r);
        chk(r == 32'h0000_FFF2, "R9 index 255", r, 32'h0000_FFF2);
        dr_put(16'h0F03, r);
        chk(r == {model[15], 16'h0F02}, "R10 done already set", r, {model[15], 16'h0F02});
    endtask

    task automatic t_serial(input int a, input int nbits, input string tag);
        int bad;
        bad = 0;
        send_cmd(3'b110, 6'(a));
        if (ctl_rdata[3] != exp_bit(a, 0)) bad++;
        for (int k = 1; k <= nbits; k++) begin
            cw(1, 0, 0);
            if (ctl_rdata[3] != exp_bit(a, k) || ctl_rdata[6:5] != 2'b11) bad++;
            cw(1, 1, 0);
        end
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic t_bad_op(input logic [2:0] op);
        int bad;
        bad = 0;
        send_cmd(op, 6'd5);
        for (int k = 1; k <= 10; k++) begin
            cw(1, 0, 0);
            if (!ctl_rdata[3]) bad++;
            cw(1, 1, 0);
        end
        chk(bad == 0, "R6 non-read opcode", bad, 0);
    endtask

    task automatic t_sel_low_hold;
        bit held;
        int bad;
        bad = 0;
        send_cmd(3'b110, 6'd7);
        for (int k = 1; k <= 3; k++) begin cw(1, 0, 0); if (k < 3) cw(1, 1, 0); end
        held = ctl_rdata[3];
        chk(held == exp_bit(7, 3), "R5 third bit", held, exp_bit(7, 3));
        cw(0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            cw(0, k[0], ~k[0]);
            if (ctl_rdata[3] != held) bad++;
        end
        chk(bad == 0, "R2 pointer held while select low", bad, 0);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 32'h0000_0015;
        @(negedge clk); ctl_wr = 1'b0;
        chk(ctl_rdata == {24'b0, 1'b0, 2'b11, 1'b1, held, 3'b101},
            "R2 stored bits", ctl_rdata, {24'b0, 1'b0, 2'b11, 1'b1, held, 3'b101});
    endtask

    task automatic t_sel_rise;
        send_cmd(3'b110, 6'd20);
        cw(1, 0, 0);
        cw(0, 0, 0);
        cw(1, 0, 0);
        chk(ctl_rdata[3] == 1'b1, "R3 rise clears read", ctl_rdata[3], 1);
        t_serial(9, 16, "R3 fresh command after rise");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_guard();
        t_load_and_seal();
        t_image_check();
        t_direct();
        t_serial(5, 16, "R4 read word 5");
        t_serial(62, 24, "R5 read runs into word 63");
        t_serial(63, 20, "R5 wrap to word 0");
        t_serial(0, 4, "R5 address 0 pre-bit from word 63");
        t_bad_op(3'b101);
        t_bad_op(3'b111);
        t_sel_low_hold();
        t_sel_rise();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule